// File: doc/BRIEF.md
# eMMC Device Bring-Up Sequencer

This block is a hardware state machine that takes a freshly powered eMMC device to a known condition. At the end the device has been identified, given a relative address, switched to an 8-bit bus and high-speed timing, and then deselected back into Stand-by. The block does not touch the CMD or DAT wires. It talks to a separate command engine through a small issue port: command index, argument, response type, two check enables and a start strobe go out; a done or error pulse and a 32-bit short response come back. It also drives the engine's configuration: open-drain mode, the card clock divider, the bus-width select and the init-stream request.

A pulse on `start` launches the fixed script. The sequencer repeats a status command between steps until the device reports the expected state. It raises `seq_done` when the script completes, or `seq_fail` on any command error or exhausted retry budget. Both flags hold until the next `start`.

Top module: `emmc_bringup_seq`

## Requirements
- R1: After reset, `cmd_start`, `od_en`, `bus_8bit`, `init_stream`, `seq_done` and `seq_fail` are low and `clk_div` equals DIV_SLOW (960).
- R2: On `start`, the sequencer first programs the slow divider and waits for `clk_stable`. It then raises `init_stream`, issues command index 0 with argument 0, no response and both checks off, and drops `init_stream` once that command completes and before any other command.
- R3: `od_en` rises after the init stream and stays high through every command up to and including the status polls that follow the address assignment. It is low before the select command and for every later command.
- R4: Command 0 is sent with no response and checks off. Command 1 is then repeated with argument 0x40FF8000, response R3 and checks off, until bit 31 of the response is 1.
- R5: Command 2 follows with response R2, CRC check on and index check off. Command 3 follows with argument 0x3A3A0000, response R1 and both checks on.
- R6: Each status poll is command 13 with argument 0x3A3A0000, response R1 and both checks on. It repeats until response bits 12:9 equal the target (3 = Stand-by after command 3 and after deselect, 4 = Transfer after select and after each switch).
- R7: Command 7 with argument 0x3A3A0000 and R1 selects the device, followed by a Transfer poll. Then command 6 with argument 0x03B70200 and R1b is sent. The sequencer waits for `xfer_done` high, polls for Transfer, and only then raises `bus_8bit`; earlier commands see `bus_8bit` low.
- R8: A second command 6 with argument 0x03B90100 and R1b is sent. The sequencer waits for `xfer_done`, polls for Transfer, then sets `clk_div` to DIV_FAST (2) and issues nothing until `clk_stable` is seen high again.
- R9: Command 7 with argument 0, no response and checks off deselects the device. After a Stand-by poll, `seq_done` goes high and `seq_fail` stays low.
- R10: A `cmd_err` pulse on any command ends the script: `seq_fail` rises and no further `cmd_start` occurs.
- R11: A polling loop (command 1 or command 13) that has issued `poll_limit` attempts without success raises `seq_fail`, having issued exactly `poll_limit` attempts.
- R12: A wait for `xfer_done` or `clk_stable` that lasts WAIT_LIMIT cycles raises `seq_fail`.
- R13: `cmd_start` is a one-cycle pulse and is never raised while a command is outstanding. Response type codes are 0 none, 1 R1, 2 R1b, 3 R2, 4 R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the bring-up script |
| poll_limit | input | CW | Maximum attempts per polling loop |
| cmd_start | output | 1 | One-cycle command issue strobe |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_type | output | 3 | Expected response type code |
| cmd_idx_chk | output | 1 | Response index check enable |
| cmd_crc_chk | output | 1 | Response CRC check enable |
| cmd_done | input | 1 | Command completed pulse |
| cmd_err | input | 1 | Command error pulse |
| cmd_resp | input | 32 | Short response word |
| xfer_done | input | 1 | Busy-release / transfer-complete level |
| clk_stable | input | 1 | Card clock stable after a divider change |
| od_en | output | 1 | Open-drain command line mode |
| clk_div | output | DW | Card clock divider |
| bus_8bit | output | 1 | 8-bit bus width select |
| init_stream | output | 1 | Init-stream request |
| seq_done | output | 1 | Script completed |
| seq_fail | output | 1 | Script aborted |

## Verification
The bench uses the default divider values and RCA, CW = 8, and WAIT_LIMIT reduced to 64. The shorter wait limit lets the stuck-busy and stuck-clock cases time out quickly. `poll_limit` is driven at 16 for normal runs and at 4 for the exhaustion runs. This makes it possible to stall the device's power-up bit or its state polls beyond the budget and count the exact number of attempts issued. The command engine model stretches its busy responses by a chosen number of polls, so each loop is exercised at zero and at several repeats.

// File: rtl/emmc_seq_pkg.sv
package emmc_seq_pkg;

  typedef enum logic [2:0] {
    RSP_NONE = 3'd0,
    RSP_R1   = 3'd1,
    RSP_R1B  = 3'd2,
    RSP_R2   = 3'd3,
    RSP_R3   = 3'd4
  } rsp_e;

  typedef enum logic [3:0] {
    OP_CLK,     // program divider, wait for stable clock
    OP_INIT,    // init-stream dummy command
    OP_OD,      // set open-drain mode from val[0]
    OP_CMD,     // single command
    OP_OPCOND,  // repeat until response bit 31 set
    OP_POLL,    // repeat status until state field == val
    OP_TC,      // wait for transfer-complete level
    OP_W8,      // switch host to 8-bit bus
    OP_END
  } op_e;

  typedef struct packed {
    op_e         op;
    logic [5:0]  idx;
    logic [31:0] arg;
    rsp_e        rsp;
    logic        ichk;
    logic        cchk;
    logic [15:0] val;
  } step_t;

  localparam int          STATE_LO    = 9;
  localparam int          STATE_HI    = 12;
  localparam logic [15:0] ST_STANDBY  = 16'd3;
  localparam logic [15:0] ST_TRANSFER = 16'd4;

endpackage

// File: rtl/emmc_script_rom.sv
module emmc_script_rom
  import emmc_seq_pkg::*;
#(
  parameter int          SW       = 5,
  parameter logic [15:0] RCA      = 16'h3A3A,
  parameter int          DIV_SLOW = 960,
  parameter int          DIV_FAST = 2
) (
  input  logic [SW-1:0] step,
  output step_t         entry
);

  localparam logic [31:0] RCA_ARG   = {RCA, 16'h0000};
  localparam logic [31:0] OCR_ARG   = 32'h40FF_8000;
  localparam logic [31:0] WIDTH_ARG = (32'd3 << 24) | (32'd183 << 16) | (32'd2 << 8);
  localparam logic [31:0] HS_ARG    = 32'h03B9_0100;

  function automatic step_t mk(op_e op, logic [5:0] idx, logic [31:0] arg,
                               rsp_e rsp, logic ic, logic cc, logic [15:0] val);
    step_t s;
    s.op = op; s.idx = idx; s.arg = arg; s.rsp = rsp;
    s.ichk = ic; s.cchk = cc; s.val = val;
    return s;
  endfunction

  always_comb begin
    case (step)
      5'd0:  entry = mk(OP_CLK,    6'd0,  32'd0,     RSP_NONE, 1'b0, 1'b0, 16'(DIV_SLOW));
      5'd1:  entry = mk(OP_INIT,   6'd0,  32'd0,     RSP_NONE, 1'b0, 1'b0, 16'd0);
      5'd2:  entry = mk(OP_OD,     6'd0,  32'd0,     RSP_NONE, 1'b0, 1'b0, 16'd1);
      5'd3:  entry = mk(OP_CMD,    6'd0,  32'd0,     RSP_NONE, 1'b0, 1'b0, 16'd0);
      5'd4:  entry = mk(OP_OPCOND, 6'd1,  OCR_ARG,   RSP_R3,   1'b0, 1'b0, 16'd0);
      5'd5:  entry = mk(OP_CMD,    6'd2,  32'd0,     RSP_R2,   1'b0, 1'b1, 16'd0);
      5'd6:  entry = mk(OP_CMD,    6'd3,  RCA_ARG,   RSP_R1,   1'b1, 1'b1, 16'd0);
      5'd7:  entry = mk(OP_POLL,   6'd13, RCA_ARG,   RSP_R1,   1'b1, 1'b1, ST_STANDBY);
      5'd8:  entry = mk(OP_OD,     6'd0,  32'd0,     RSP_NONE, 1'b0, 1'b0, 16'd0);
      5'd9:  entry = mk(OP_CMD,    6'd7,  RCA_ARG,   RSP_R1,   1'b1, 1'b1, 16'd0);
      5'd10: entry = mk(OP_POLL,   6'd13, RCA_ARG,   RSP_R1,   1'b1, 1'b1, ST_TRANSFER);
      5'd11: entry = mk(OP_CMD,    6'd6,  WIDTH_ARG, RSP_R1B,  1'b1, 1'b1, 16'd0);
      5'd12: entry = mk(OP_TC,     6'd0,  32'd0,     RSP_NONE, 1'b0, 1'b0, 16'd0);
      5'd13: entry = mk(OP_POLL,   6'd13, RCA_ARG,   RSP_R1,   1'b1, 1'b1, ST_TRANSFER);
      5'd14: entry = mk(OP_W8,     6'd0,  32'd0,     RSP_NONE, 1'b0, 1'b0, 16'd0);
      5'd15: entry = mk(OP_CMD,    6'd6,  HS_ARG,    RSP_R1B,  1'b1, 1'b1, 16'd0);
      5'd16: entry = mk(OP_TC,     6'd0,  32'd0,     RSP_NONE, 1'b0, 1'b0, 16'd0);
      5'd17: entry = mk(OP_POLL,   6'd13, RCA_ARG,   RSP_R1,   1'b1, 1'b1, ST_TRANSFER);
      5'd18: entry = mk(OP_CLK,    6'd0,  32'd0,     RSP_NONE, 1'b0, 1'b0, 16'(DIV_FAST));
      5'd19: entry = mk(OP_CMD,    6'd7,  32'd0,     RSP_NONE, 1'b0, 1'b0, 16'd0);
      5'd20: entry = mk(OP_POLL,   6'd13, RCA_ARG,   RSP_R1,   1'b1, 1'b1, ST_STANDBY);
      default: entry = mk(OP_END,  6'd0,  32'd0,     RSP_NONE, 1'b0, 1'b0, 16'd0);
    endcase
  end

endmodule

// File: rtl/emmc_retry_ctr.sv
module emmc_retry_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         at_limit
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  // true when the attempt now ending is the last one the budget allows
  assign at_limit = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};

  // R11
  ctl_excl_chk: assert property (@(posedge clk) disable iff (rst) !(clr && inc));

endmodule

// File: rtl/emmc_bringup_seq.sv
module emmc_bringup_seq
  import emmc_seq_pkg::*;
#(
  parameter int          DW         = 10,
  parameter int          CW         = 8,
  parameter int          WAIT_LIMIT = 4096,
  parameter logic [15:0] RCA        = 16'h3A3A,
  parameter int          DIV_SLOW   = 960,
  parameter int          DIV_FAST   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] poll_limit,
  output logic          cmd_start,
  output logic [5:0]    cmd_idx,
  output logic [31:0]   cmd_arg,
  output logic [2:0]    cmd_rsp_type,
  output logic          cmd_idx_chk,
  output logic          cmd_crc_chk,
  input  logic          cmd_done,
  input  logic          cmd_err,
  input  logic [31:0]   cmd_resp,
  input  logic          xfer_done,
  input  logic          clk_stable,
  output logic          od_en,
  output logic [DW-1:0] clk_div,
  output logic          bus_8bit,
  output logic          init_stream,
  output logic          seq_done,
  output logic          seq_fail
);

  localparam int NSTEP = 22;
  localparam int SW    = $clog2(NSTEP);
  localparam int WCW   = $clog2(WAIT_LIMIT + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_EXEC, S_WAITR, S_SETTLE, S_WAITC, S_WAITT, S_DONE, S_FAIL
  } fsm_e;

  fsm_e          state_q, state_n;
  logic [SW-1:0] step_q;
  step_t         ent;
  logic          launch, adv, go_fail, issue;
  logic          r_inc, r_at, w_inc, w_at;
  logic          state_hit;

  emmc_script_rom #(
    .SW(SW), .RCA(RCA), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)
  ) u_rom (
    .step (step_q),
    .entry(ent)
  );

  emmc_retry_ctr #(.W(CW)) u_poll_ctr (
    .clk(clk), .rst(rst), .clr(adv || launch), .inc(r_inc),
    .limit(poll_limit), .at_limit(r_at)
  );

  emmc_retry_ctr #(.W(WCW)) u_wait_ctr (
    .clk(clk), .rst(rst), .clr(adv || launch), .inc(w_inc),
    .limit(WCW'(WAIT_LIMIT)), .at_limit(w_at)
  );

  assign state_hit = (cmd_resp[STATE_HI:STATE_LO] == ent.val[3:0]);

  always_comb begin
    state_n = state_q;
    launch  = 1'b0;
    adv     = 1'b0;
    go_fail = 1'b0;
    issue   = 1'b0;
    r_inc   = 1'b0;
    w_inc   = 1'b0;
    case (state_q)
      S_IDLE, S_DONE, S_FAIL: if (start) begin
        launch  = 1'b1;
        state_n = S_EXEC;
      end
      S_EXEC: case (ent.op)
        OP_CLK:        state_n = S_SETTLE;
        OP_OD, OP_W8:  adv = 1'b1;
        OP_TC:         state_n = S_WAITT;
        OP_END:        state_n = S_DONE;
        default: begin
          issue   = 1'b1;
          state_n = S_WAITR;
        end
      endcase
      S_SETTLE: state_n = S_WAITC;
      S_WAITC: begin
        if (clk_stable) adv = 1'b1;
        else if (w_at)  go_fail = 1'b1;
        else            w_inc = 1'b1;
      end
      S_WAITT: begin
        if (xfer_done) adv = 1'b1;
        else if (w_at) go_fail = 1'b1;
        else           w_inc = 1'b1;
      end
      S_WAITR: begin
        if (cmd_err) go_fail = 1'b1;
        else if (cmd_done) begin
          if ((ent.op == OP_OPCOND && cmd_resp[31]) ||
              (ent.op == OP_POLL && state_hit) ||
              (ent.op != OP_OPCOND && ent.op != OP_POLL)) adv = 1'b1;
          else if (r_at) go_fail = 1'b1;
          else begin
            r_inc   = 1'b1;
            state_n = S_EXEC;
          end
        end
      end
      default: state_n = S_IDLE;
    endcase
    if (adv)     state_n = S_EXEC;
    if (go_fail) state_n = S_FAIL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      step_q       <= '0;
      cmd_start    <= 1'b0;
      cmd_idx      <= '0;
      cmd_arg      <= '0;
      cmd_rsp_type <= RSP_NONE;
      cmd_idx_chk  <= 1'b0;
      cmd_crc_chk  <= 1'b0;
      od_en        <= 1'b0;
      clk_div      <= DW'(DIV_SLOW);
      bus_8bit     <= 1'b0;
      init_stream  <= 1'b0;
      seq_done     <= 1'b0;
      seq_fail     <= 1'b0;
    end else begin
      state_q   <= state_n;
      cmd_start <= issue;
      if (launch) begin
        step_q      <= '0;
        od_en       <= 1'b0;
        bus_8bit    <= 1'b0;
        init_stream <= 1'b0;
        seq_done    <= 1'b0;
        seq_fail    <= 1'b0;
      end else if (adv) begin
        step_q <= step_q + SW'(1);
      end
      if (state_q == S_EXEC) begin
        case (ent.op)
          OP_CLK: clk_div  <= ent.val[DW-1:0];
          OP_OD:  od_en    <= ent.val[0];
          OP_W8:  bus_8bit <= 1'b1;
          OP_END: seq_done <= 1'b1;
          default: ;
        endcase
      end
      if (issue) begin
        cmd_idx      <= ent.idx;
        cmd_arg      <= ent.arg;
        cmd_rsp_type <= ent.rsp;
        cmd_idx_chk  <= ent.ichk;
        cmd_crc_chk  <= ent.cchk;
        if (ent.op == OP_INIT) init_stream <= 1'b1;
      end
      if (state_q == S_WAITR && adv && ent.op == OP_INIT) init_stream <= 1'b0;
      if (go_fail) begin
        seq_fail    <= 1'b1;
        init_stream <= 1'b0;
      end
    end
  end

  // R13
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !cmd_start);

  // R10
  fail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    seq_fail |-> !cmd_start);

  // R10
  err_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAITR && cmd_err) |=> seq_fail);

  // R9
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(seq_done && seq_fail));

  // R3
  od_width_chk: assert property (@(posedge clk) disable iff (rst)
    bus_8bit |-> !od_en);

  // R2
  init_dummy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && init_stream) |-> (cmd_idx == 6'd0 && cmd_arg == 32'd0 &&
                                    cmd_rsp_type == RSP_NONE));

  // R8
  div_settle_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_div) |-> !cmd_start);

endmodule

// File: tb/emmc_bringup_seq_test.sv
module emmc_bringup_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 10;
  localparam int CW         = 8;
  localparam int WAIT_LIM   = 64;
  localparam int SLOW       = 960;
  localparam int FAST       = 2;
  localparam logic [31:0] RA = 32'h3A3A_0000;
  localparam int LOGN       = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] poll_limit = 8'd16;
  logic          cmd_start;
  logic [5:0]    cmd_idx;
  logic [31:0]   cmd_arg;
  logic [2:0]    cmd_rsp_type;
  logic          cmd_idx_chk, cmd_crc_chk;
  logic          cmd_done = 1'b0, cmd_err = 1'b0;
  logic [31:0]   cmd_resp = '0;
  logic          xfer_done = 1'b0, clk_stable = 1'b1;
  logic          od_en;
  logic [DW-1:0] clk_div;
  logic          bus_8bit, init_stream, seq_done, seq_fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  emmc_bringup_seq #(.DW(DW), .CW(CW), .WAIT_LIMIT(WAIT_LIM)) uut (
    .clk(clk), .rst(rst), .start(start), .poll_limit(poll_limit),
    .cmd_start(cmd_start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .cmd_rsp_type(cmd_rsp_type), .cmd_idx_chk(cmd_idx_chk), .cmd_crc_chk(cmd_crc_chk),
    .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_resp(cmd_resp),
    .xfer_done(xfer_done), .clk_stable(clk_stable), .od_en(od_en),
    .clk_div(clk_div), .bus_8bit(bus_8bit), .init_stream(init_stream),
    .seq_done(seq_done), .seq_fail(seq_fail)
  );

  int checks = 0, fails = 0;

  // model knobs
  int busy_ocr = 0, busy_poll = 0, err_at = -1;
  bit tc_block = 0, clk_never = 0;

  // command log: {idx,arg,rsp,ichk,cchk,od,w8,div,init}
  logic [5:0]    l_idx [LOGN];
  logic [31:0]   l_arg [LOGN];
  logic [2:0]    l_rsp [LOGN];
  logic [1:0]    l_chk [LOGN];
  logic [2:0]    l_cfg [LOGN];
  logic [DW-1:0] l_div [LOGN];
  int            lcnt;

  logic [5:0]    e_idx [LOGN];
  logic [31:0]   e_arg [LOGN];
  logic [2:0]    e_rsp [LOGN];
  logic [1:0]    e_chk [LOGN];
  logic [2:0]    e_cfg [LOGN];
  logic [DW-1:0] e_div [LOGN];
  int            ecnt;

  // command engine and card model
  logic        busy;
  int          dly, cur_num, ocr_cnt, pend;
  logic [5:0]  cur_idx;
  logic [31:0] cur_arg;
  logic [2:0]  cur_rsp;
  logic [3:0]  tgt;
  int          viol;

  always @(posedge clk) begin
    cmd_done <= 1'b0;
    cmd_err  <= 1'b0;
    if (rst) begin
      busy <= 1'b0; lcnt <= 0; ocr_cnt <= 0; pend <= 0; tgt <= 4'd2;
      xfer_done <= 1'b0; viol <= 0; dly <= 0; cur_num <= 0;
    end else if (cmd_start) begin
      if (busy) viol <= viol + 1;
      if (lcnt < LOGN) begin
        l_idx[lcnt] <= cmd_idx; l_arg[lcnt] <= cmd_arg; l_rsp[lcnt] <= cmd_rsp_type;
        l_chk[lcnt] <= {cmd_idx_chk, cmd_crc_chk};
        l_cfg[lcnt] <= {od_en, bus_8bit, init_stream};
        l_div[lcnt] <= clk_div;
      end
      cur_num <= lcnt; lcnt <= lcnt + 1;
      busy <= 1'b1; dly <= 2;
      cur_idx <= cmd_idx; cur_arg <= cmd_arg; cur_rsp <= cmd_rsp_type;
      xfer_done <= 1'b0;
    end else if (busy) begin
      if (dly != 0) dly <= dly - 1;
      else begin
        busy <= 1'b0;
        if (cur_num == err_at) cmd_err <= 1'b1;
        else begin
          cmd_done <= 1'b1;
          cmd_resp <= 32'h0;
          if (cur_rsp == 3'd2 && !tc_block) xfer_done <= 1'b1;
          case (cur_idx)
            6'd1: begin
              cmd_resp <= (ocr_cnt >= busy_ocr) ? 32'hC0FF_8080 : 32'h00FF_8080;
              ocr_cnt <= ocr_cnt + 1;
            end
            6'd3: begin tgt <= 4'd3; pend <= busy_poll; end
            6'd7: begin tgt <= (cur_arg != 0) ? 4'd4 : 4'd3; pend <= busy_poll; end
            6'd6: begin tgt <= 4'd4; pend <= busy_poll; end
            6'd13: begin
              if (pend != 0) begin
                cmd_resp <= 32'd7 << 9; pend <= pend - 1;
              end else cmd_resp <= {19'd0, tgt, 9'd0};
            end
            default: ;
          endcase
        end
      end
    end
  end

  logic [DW-1:0] last_div;
  int            scnt;
  always @(posedge clk) begin
    last_div <= clk_div;
    if (rst) begin clk_stable <= !clk_never; scnt <= 0; end
    else if (clk_never) clk_stable <= 1'b0;
    else if (clk_div != last_div) begin clk_stable <= 1'b0; scnt <= 3; end
    else if (scnt != 0) scnt <= scnt - 1;
    else clk_stable <= 1'b1;
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(logic [5:0] idx, logic [31:0] arg, logic ini);
    if (ini) return "R2";
    case (idx)
      6'd0, 6'd1: return "R4";
      6'd2, 6'd3: return "R5";
      6'd13:      return "R6";
      6'd7:       return (arg != 0) ? "R7" : "R9";
      6'd6:       return (arg == 32'h03B7_0200) ? "R7" : "R8";
      default:    return "R13";
    endcase
  endfunction

  bit x_od, x_w8, x_init;
  logic [DW-1:0] x_div;

  task automatic push(logic [5:0] idx, logic [31:0] arg, logic [2:0] rsp, logic [1:0] c);
    e_idx[ecnt] = idx; e_arg[ecnt] = arg; e_rsp[ecnt] = rsp; e_chk[ecnt] = c;
    e_cfg[ecnt] = {x_od, x_w8, x_init}; e_div[ecnt] = x_div;
    ecnt++;
  endtask

  task automatic push_polls(int n);
    for (int i = 0; i < n; i++) push(6'd13, RA, 3'd1, 2'b11);
  endtask

  // expected command stream for a full run from the requirements
  task automatic build_full(int b, int p);
    ecnt = 0; x_div = DW'(SLOW); x_od = 0; x_w8 = 0; x_init = 1;
    push(6'd0, 32'd0, 3'd0, 2'b00);                                 // R2
    x_init = 0; x_od = 1;                                           // R3
    push(6'd0, 32'd0, 3'd0, 2'b00);                                 // R4
    for (int i = 0; i <= b; i++) push(6'd1, 32'h40FF_8000, 3'd4, 2'b00);
    push(6'd2, 32'd0, 3'd3, 2'b01);                                 // R5
    push(6'd3, RA, 3'd1, 2'b11);
    push_polls(p + 1);                                              // R6
    x_od = 0;
    push(6'd7, RA, 3'd1, 2'b11);                                    // R7
    push_polls(p + 1);
    push(6'd6, 32'h03B7_0200, 3'd2, 2'b11);
    push_polls(p + 1);
    x_w8 = 1;
    push(6'd6, 32'h03B9_0100, 3'd2, 2'b11);                         // R8
    push_polls(p + 1);
    x_div = DW'(FAST);
    push(6'd7, 32'd0, 3'd0, 2'b00);                                 // R9
    push_polls(p + 1);
  endtask

  task automatic compare_log(int upto);
    for (int i = 0; i < upto && i < LOGN; i++) begin
      chk(req_of(e_idx[i], e_arg[i], e_cfg[i][0]), $sformatf("cmd #%0d", i),
          {l_idx[i], l_arg[i], l_rsp[i], l_chk[i], l_cfg[i], l_div[i]},
          {e_idx[i], e_arg[i], e_rsp[i], e_chk[i], e_cfg[i], e_div[i]});
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_seq();
    int n = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!seq_done && !seq_fail && n < 20000) begin
      @(negedge clk); n++;
    end
    if (n >= 20000) chk("R9", "sequence finished in time", 0, 1);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    busy_ocr = 0; busy_poll = 0; err_at = -1; tc_block = 0; clk_never = 0;
    do_reset();
    chk("R1", "cmd_start", cmd_start, 0);
    chk("R1", "od_en", od_en, 0);
    chk("R1", "bus_8bit", bus_8bit, 0);
    chk("R1", "init_stream", init_stream, 0);
    chk("R1", "done/fail", {seq_done, seq_fail}, 0);
    chk("R1", "clk_div", clk_div, SLOW);
  endtask

  task automatic t_full(int b, int p);
    busy_ocr = b; busy_poll = p; err_at = -1; tc_block = 0; clk_never = 0;
    poll_limit = 8'd16;
    do_reset();
    build_full(b, p);
    run_seq();
    chk("R9", "command count", lcnt, ecnt);
    compare_log(ecnt);
    chk("R9", "seq_done/seq_fail", {seq_done, seq_fail}, 2'b10);
    chk("R7", "bus_8bit at end", bus_8bit, 1);
    chk("R8", "clk_div at end", clk_div, FAST);
    chk("R3", "od_en at end", od_en, 0);
    chk("R13", "overlapping or stretched starts", viol, 0);
  endtask

  task automatic t_cmd_err();
    busy_ocr = 1; busy_poll = 0; err_at = 4; tc_block = 0; clk_never = 0;
    do_reset();
    build_full(1, 0);
    run_seq();
    // entry 4 is the CMD2 after two CMD1 attempts; nothing may follow it
    chk("R10", "commands issued before abort", lcnt, 5);
    compare_log(5);
    chk("R10", "seq_fail/seq_done", {seq_fail, seq_done}, 2'b10);
    repeat (20) @(negedge clk);
    chk("R10", "no command after fail", lcnt, 5);
  endtask

  task automatic t_ocr_exhaust();
    busy_ocr = 10; busy_poll = 0; err_at = -1; tc_block = 0; clk_never = 0;
    poll_limit = 8'd4;
    do_reset();
    run_seq();
    chk("R11", "CMD1 attempts before fail", lcnt, 2 + 4);
    chk("R11", "seq_fail", {seq_fail, seq_done}, 2'b10);
    poll_limit = 8'd16;
  endtask

  task automatic t_poll_exhaust();
    busy_ocr = 0; busy_poll = 10; err_at = -1; tc_block = 0; clk_never = 0;
    poll_limit = 8'd4;
    do_reset();
    run_seq();
    // init, CMD0, CMD1, CMD2, CMD3, then exactly 4 status polls
    chk("R11", "status polls before fail", lcnt, 5 + 4);
    chk("R11", "last command is status", l_idx[8], 13);
    chk("R11", "seq_fail", {seq_fail, seq_done}, 2'b10);
    poll_limit = 8'd16;
  endtask

  task automatic t_tc_timeout();
    busy_ocr = 0; busy_poll = 0; err_at = -1; tc_block = 1; clk_never = 0;
    do_reset();
    run_seq();
    chk("R12", "commands up to first switch", lcnt, 9);
    chk("R12", "last command index", l_idx[8], 6);
    chk("R12", "seq_fail", {seq_fail, seq_done}, 2'b10);
    chk("R7", "width not switched", bus_8bit, 0);
  endtask

  task automatic t_clk_timeout();
    busy_ocr = 0; busy_poll = 0; err_at = -1; tc_block = 0; clk_never = 1;
    do_reset();
    run_seq();
    chk("R12", "no command without stable clock", lcnt, 0);
    chk("R12", "seq_fail", {seq_fail, seq_done}, 2'b10);
    chk("R2", "init_stream never raised", init_stream, 0);
    clk_never = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_full(0, 0);
    t_full(3, 2);
    t_cmd_err();
    t_ocr_exhaust();
    t_poll_exhaust();
    t_tc_timeout();
    t_clk_timeout();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule